// File: doc/BRIEF.md
# Counter Clock and Gate Routing Matrix

This block chooses, for every channel of a bank of counters, which signal advances the channel and which signal gates it. The counters come as groups. Each group holds two three-channel counters, so the default of three groups gives eighteen channels. Software sets up one channel at a time by writing a single byte to a per-group clock-select or gate-select register. That byte packs three things: which counter of the group is meant, which channel of that counter, and a five-bit source number. The top two source bits are split off from the low three.

A prescaler chain runs from the master clock, nominally 20 MHz, and produces single-cycle enable pulses at 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz. For every channel, the block drives a counting enable (`ctr_clk_en`) and a gate level (`ctr_gate`). Everything stays in the master clock domain. An enhance register widens the accepted source range from 0–7 to 0–31. For one bus variant, register offsets are spaced eight bytes apart, and a parameter sets this stride. The routing state of any channel can be read back at any time.

Top module: `cgr_routing_matrix`

## Requirements
- R1: After reset, every channel's clock and gate selection reads back 0. `ctr_gate` is all ones and `ctr_clk_en` equals `ext_clk`.
- R2: A write at offset 0x18+g (group g = 0..2) sets the clock selection of one channel only. The target is g*6 + 3*data[5] + data[4:3].
- R3: A write at offset 0x1B+g sets the gate selection of the same target channel, decoded in the same way.
- R4: A select byte whose channel field data[4:3] equals 3 changes no selection.
- R5: In normal mode the stored source is data[2:0]. Bits 7:6 are disregarded, so every stored source is in 0–7.
- R6: Writing 0x01 to offset 0x20 enters enhanced mode, where the stored source is {data[7:6], data[2:0]}. Writing any other value to 0x20 returns to normal mode. A source is stored as it was decoded at write time.
- R7: Clock source 0 routes the channel's `ext_clk` bit. Gate source 0 gives constant 1. Gate source 1 routes the channel's `ext_gate` bit.
- R8: Clock sources give enable pulses at these rates: 1 every 2 cycles, 2 every 20, 3 every 200, 4 every 2000 and 5 every 20000. Source 11 gives a pulse every cycle. No pulse lasts more than one cycle at any rate below the master clock.
- R9: Every clock source other than 0–5 and 11, and every gate source other than 0 and 1, drives a constant 0.
- R10: With ADDR_SHIFT = s, a register at offset o is reached at bus address o << s. Addresses whose low s bits are not zero are ignored.
- R11: `rd_clk_src` and `rd_gate_src` show the stored selections of channel `rd_chan` combinationally. They show 0 when `rd_chan` is 18 or more.
- R12: A write to any offset other than 0x18–0x1D and 0x20 changes no selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominal 20 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W (9) | Byte address of the write |
| wr_data | input | 8 | Write data byte |
| ext_clk | input | NCH (18) | Per-channel dedicated clock enables from pins |
| ext_gate | input | NCH (18) | Per-channel external gate levels |
| ctr_clk_en | output | NCH (18) | Selected counting enable for each channel |
| ctr_gate | output | NCH (18) | Selected gate level for each channel |
| rd_chan | input | CHAN_W (5) | Channel index for read-back |
| rd_clk_src | output | 5 | Stored clock source of `rd_chan` |
| rd_gate_src | output | 5 | Stored gate source of `rd_chan` |

## Verification
Different faults in this block show up at the ports in different ways:

- **Wrong target decode.** The mistake is visible at the read-back port in the first cycle after the write that caused it, because selection state is read back combinationally. For that reason, every write is followed by a sweep over all channels, not just the intended one.
- **Wrong source mapping.** The neighbouring channel's enable pins carry the wrong rate. It is visible within one period of the expected rate.
- **Prescaler miscount.** It only appears as a wrong pulse count over a full window, so pulse counts are taken over windows that are exact multiples of each period, up to 20000 cycles.
- **Stuck mode bit.** It changes what the next enhanced-range write stores, and read-back exposes that at once.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  // select byte format fixes two counters of three channels per group
  localparam int CTRS_PER_GRP = 2;
  localparam int CH_PER_CTR   = 3;
  localparam int CH_PER_GRP   = CTRS_PER_GRP * CH_PER_CTR;
  localparam int SRC_W        = 5;

  typedef logic [SRC_W-1:0] src_t;

  localparam src_t CLK_SRC_PIN   = 5'd0;
  localparam src_t CLK_SRC_FAST  = 5'd11;
  localparam src_t GATE_SRC_HIGH = 5'd0;
  localparam src_t GATE_SRC_PIN  = 5'd1;
  localparam logic [1:0] CH_FIELD_NONE = 2'd3;

  // reassemble the split source number from a select byte
  function automatic src_t unpack_src(input logic [7:0] b, input logic wide);
    return wide ? {b[7:6], b[2:0]} : {2'b00, b[2:0]};
  endfunction
endpackage

// File: rtl/cgr_div_stage.sv
module cgr_div_stage #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_tick,
  output logic out_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign out_tick = in_tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (in_tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R8

  if (DIV > 1) begin : g_gap
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |=> !out_tick); // R8
  end
endmodule

// File: rtl/cgr_prescaler.sv
module cgr_prescaler #(
  parameter int FIRST_DIV   = 2,
  parameter int DECADE_DIV  = 10,
  parameter int NUM_DECADES = 4,
  localparam int NUM_REF    = NUM_DECADES + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_REF-1:0] ref_tick
);
  // ref_tick[0] is the master rate, each further bit a slower tap
  assign ref_tick[0] = 1'b1;

  cgr_div_stage #(.DIV(FIRST_DIV)) u_first (
    .clk(clk), .rst_n(rst_n), .in_tick(ref_tick[0]), .out_tick(ref_tick[1])
  );

  for (genvar g = 0; g < NUM_DECADES; g++) begin : g_dec
    cgr_div_stage #(.DIV(DECADE_DIV)) u_stage (
      .clk(clk), .rst_n(rst_n), .in_tick(ref_tick[g+1]), .out_tick(ref_tick[g+2])
    );
  end
endmodule

// File: rtl/cgr_wr_decode.sv
module cgr_wr_decode
  import cgr_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int ADDR_W     = 9,
  parameter int ADDR_SHIFT = 0,
  parameter int CLK_BASE   = 24,
  parameter int ENH_OFF    = 32,
  localparam int NCH       = NUM_GROUPS * CH_PER_GRP,
  localparam int GATE_BASE = CLK_BASE + NUM_GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NCH-1:0]    clk_hit,
  output logic [NCH-1:0]    gate_hit,
  output src_t              wr_src,
  output logic              enh_o
);
  logic [ADDR_W-1:0] off;
  logic              aligned;
  int                off_i;
  logic              in_clk, in_gate, ch_ok;
  int                grp_i, tgt_i;
  logic              enh_q;

  assign off     = wr_addr >> ADDR_SHIFT;
  assign aligned = ((off << ADDR_SHIFT) == wr_addr);
  assign off_i   = int'(off);
  assign in_clk  = aligned && (off_i >= CLK_BASE)  && (off_i < CLK_BASE + NUM_GROUPS);
  assign in_gate = aligned && (off_i >= GATE_BASE) && (off_i < GATE_BASE + NUM_GROUPS);
  assign ch_ok   = (wr_data[4:3] != CH_FIELD_NONE);
  assign grp_i   = in_clk ? (off_i - CLK_BASE) : (off_i - GATE_BASE);
  assign tgt_i   = grp_i * CH_PER_GRP + (wr_data[5] ? CH_PER_CTR : 0) + int'(wr_data[4:3]);
  assign wr_src  = unpack_src(wr_data, enh_q);
  assign enh_o   = enh_q;

  always_comb begin
    clk_hit  = '0;
    gate_hit = '0;
    if (wr_en && ch_ok) begin
      for (int i = 0; i < NCH; i++) begin
        if (in_clk  && tgt_i == i) clk_hit[i]  = 1'b1;
        if (in_gate && tgt_i == i) gate_hit[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) enh_q <= 1'b0;
    else if (wr_en && aligned && off_i == ENH_OFF) enh_q <= (wr_data == 8'h01);
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clk_hit, gate_hit})); // R2
endmodule

// File: rtl/cgr_sel_regs.sv
module cgr_sel_regs
  import cgr_pkg::*;
#(
  parameter int NCH = 18
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            clk_hit,
  input  logic [NCH-1:0]            gate_hit,
  input  src_t                      wr_src,
  input  logic                      enh,
  output logic [NCH-1:0][SRC_W-1:0] clk_sel,
  output logic [NCH-1:0][SRC_W-1:0] gate_sel
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        clk_sel[i]  <= CLK_SRC_PIN;
        gate_sel[i] <= GATE_SRC_HIGH;
      end else begin
        if (clk_hit[i])  clk_sel[i]  <= wr_src;
        if (gate_hit[i]) gate_sel[i] <= wr_src;
      end
    end

    AST_NARROW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_hit[i] && !enh) |=> (clk_sel[i][4:3] == 2'b00)); // R5
    AST_NARROW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hit[i] && !enh) |=> (gate_sel[i][4:3] == 2'b00)); // R5
  end

  AST_HOLD_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !(|clk_hit) |=> $stable(clk_sel)); // R2
  AST_HOLD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|gate_hit) |=> $stable(gate_sel)); // R3
endmodule

// File: rtl/cgr_route.sv
module cgr_route
  import cgr_pkg::*;
#(
  parameter int NCH     = 18,
  parameter int NUM_REF = 6
) (
  input  logic [NCH-1:0][SRC_W-1:0] clk_sel,
  input  logic [NCH-1:0][SRC_W-1:0] gate_sel,
  input  logic [NUM_REF-1:0]        ref_tick,
  input  logic [NCH-1:0]            ext_clk,
  input  logic [NCH-1:0]            ext_gate,
  output logic [NCH-1:0]            ctr_clk_en,
  output logic [NCH-1:0]            ctr_gate
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      ctr_clk_en[i] = 1'b0;
      if (clk_sel[i] == CLK_SRC_PIN)       ctr_clk_en[i] = ext_clk[i];
      else if (clk_sel[i] == CLK_SRC_FAST) ctr_clk_en[i] = ref_tick[0];
      else begin
        for (int k = 1; k < NUM_REF; k++) begin
          if (clk_sel[i] == src_t'(k)) ctr_clk_en[i] = ref_tick[k];
        end
      end
    end

    always_comb begin
      unique case (gate_sel[i])
        GATE_SRC_HIGH: ctr_gate[i] = 1'b1;
        GATE_SRC_PIN:  ctr_gate[i] = ext_gate[i];
        default:       ctr_gate[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cgr_routing_matrix.sv
module cgr_routing_matrix
  import cgr_pkg::*;
#(
  parameter int NUM_GROUPS  = 3,
  parameter int ADDR_W      = 9,
  parameter int ADDR_SHIFT  = 0,
  parameter int CLK_BASE    = 24,
  parameter int ENH_OFF     = 32,
  parameter int FIRST_DIV   = 2,
  parameter int DECADE_DIV  = 10,
  parameter int NUM_DECADES = 4,
  localparam int NCH        = NUM_GROUPS * CH_PER_GRP,
  localparam int CHAN_W     = $clog2(NCH),
  localparam int NUM_REF    = NUM_DECADES + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NCH-1:0]    ext_clk,
  input  logic [NCH-1:0]    ext_gate,
  output logic [NCH-1:0]    ctr_clk_en,
  output logic [NCH-1:0]    ctr_gate,
  input  logic [CHAN_W-1:0] rd_chan,
  output logic [SRC_W-1:0]  rd_clk_src,
  output logic [SRC_W-1:0]  rd_gate_src
);
  logic [NCH-1:0]            clk_hit, gate_hit;
  src_t                      wr_src;
  logic                      enh;
  logic [NCH-1:0][SRC_W-1:0] clk_sel, gate_sel;
  logic [NUM_REF-1:0]        ref_tick;

  cgr_prescaler #(
    .FIRST_DIV(FIRST_DIV), .DECADE_DIV(DECADE_DIV), .NUM_DECADES(NUM_DECADES)
  ) u_presc (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick)
  );

  cgr_wr_decode #(
    .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT),
    .CLK_BASE(CLK_BASE), .ENH_OFF(ENH_OFF)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_hit(clk_hit), .gate_hit(gate_hit), .wr_src(wr_src), .enh_o(enh)
  );

  cgr_sel_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .clk_hit(clk_hit), .gate_hit(gate_hit),
    .wr_src(wr_src), .enh(enh), .clk_sel(clk_sel), .gate_sel(gate_sel)
  );

  cgr_route #(.NCH(NCH), .NUM_REF(NUM_REF)) u_route (
    .clk_sel(clk_sel), .gate_sel(gate_sel), .ref_tick(ref_tick),
    .ext_clk(ext_clk), .ext_gate(ext_gate),
    .ctr_clk_en(ctr_clk_en), .ctr_gate(ctr_gate)
  );

  always_comb begin
    rd_clk_src  = '0;
    rd_gate_src = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_chan == CHAN_W'(i)) begin
        rd_clk_src  = clk_sel[i];
        rd_gate_src = gate_sel[i];
      end
    end
  end

  AST_CH3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4:3] == CH_FIELD_NONE) |=> ($stable(clk_sel) && $stable(gate_sel))); // R4
  AST_FAST_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick[0]); // R8
endmodule

// File: tb/test_cgr_routing_matrix.sv
module test_cgr_routing_matrix;
  localparam int NCH = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic           wr_en = 1'b0;
  logic [8:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [NCH-1:0] ext_clk = '0, ext_gate = '0;
  logic [NCH-1:0] ctr_clk_en, ctr_gate;
  logic [4:0]     rd_chan = '0;
  logic [4:0]     rd_clk_src, rd_gate_src;

  logic           w_wr_en = 1'b0;
  logic [8:0]     w_wr_addr = '0;
  logic [7:0]     w_wr_data = '0;
  logic [NCH-1:0] w_clk_en, w_gate;
  logic [4:0]     w_rd_chan = '0;
  logic [4:0]     w_rd_clk, w_rd_gate;

  cgr_routing_matrix i_cgr_routing_matrix (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_clk(ext_clk), .ext_gate(ext_gate), .ctr_clk_en(ctr_clk_en), .ctr_gate(ctr_gate),
    .rd_chan(rd_chan), .rd_clk_src(rd_clk_src), .rd_gate_src(rd_gate_src)
  );

  cgr_routing_matrix #(.ADDR_SHIFT(3)) i_wide (
    .clk(clk), .rst_n(rst_n), .wr_en(w_wr_en), .wr_addr(w_wr_addr), .wr_data(w_wr_data),
    .ext_clk(ext_clk), .ext_gate(ext_gate), .ctr_clk_en(w_clk_en), .ctr_gate(w_gate),
    .rd_chan(w_rd_chan), .rd_clk_src(w_rd_clk), .rd_gate_src(w_rd_gate)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int    chan;
    int    clk_s;
    int    gate_s;
    string req;
  } sb_item_t;
  sb_item_t sbq[$];

  // independent model of the selection state
  int m_clk[NCH];
  int m_gate[NCH];
  bit m_enh = 0;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic push_all(input string req);
    for (int c = 0; c < 21; c++) begin
      sb_item_t it;
      it.chan = c;
      it.clk_s = (c < NCH) ? m_clk[c] : 0;
      it.gate_s = (c < NCH) ? m_gate[c] : 0;
      it.req = req;
      sbq.push_back(it);
    end
    wait (sbq.size() == 0);
    @(negedge clk);
  endtask

  task automatic drive_wr(input int a, input logic [7:0] d, input string req);
    int src, idx;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 9'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    src = m_enh ? int'({d[7:6], d[2:0]}) : int'(d[2:0]);
    idx = (d[5] ? 3 : 0) + int'(d[4:3]);
    if (a == 32) m_enh = (d == 8'h01);
    else if (d[4:3] != 2'd3) begin
      if (a >= 24 && a <= 26) m_clk[(a - 24) * 6 + idx] = src;
      if (a >= 27 && a <= 29) m_gate[(a - 27) * 6 + idx] = src;
    end
    push_all(req);
  endtask

  // monitor: pops expected selections and compares read-back
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        sb_item_t it;
        it = sbq[0];
        rd_chan = 5'(it.chan);
        #2;
        check({it.req, " clk_sel"}, int'(rd_clk_src), it.clk_s);
        check({it.req, " gate_sel"}, int'(rd_gate_src), it.gate_s);
        void'(sbq.pop_front());
      end
    end
  end

  task automatic count_ticks(input int ch, input int n, input int exp, input string req);
    int c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      if (ctr_clk_en[ch]) c++;
    end
    check(req, c, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_clk[c] = 0; m_gate[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ext_clk = 18'h2A5A5; ext_gate = 18'h15A5A;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 gate all high", int'(ctr_gate), int'(18'h3FFFF));
    check("R1 clk follows pins", int'(ctr_clk_en), int'(ext_clk));
    push_all("R1");

    // R2 clock select group1 ctr1 ch2 src3 -> channel 11
    drive_wr(25, 8'h33, "R2");
    // R3 gate select group2 ctr0 ch0 src1 -> channel 12
    drive_wr(29, 8'h01, "R3");
    ext_gate[12] = 1'b0; #1;
    check("R7 gate pin low", int'(ctr_gate[12]), 0);
    ext_gate[12] = 1'b1; #1;
    check("R7 gate pin high", int'(ctr_gate[12]), 1);
    ext_clk[7] = 1'b1; #1;
    check("R7 clk pin high", int'(ctr_clk_en[7]), 1);
    ext_clk[7] = 1'b0; #1;
    check("R7 clk pin low", int'(ctr_clk_en[7]), 0);
    // R4 channel field 3 ignored
    drive_wr(24, 8'h1B, "R4");
    drive_wr(27, 8'h1D, "R4");
    // R5 normal mode drops bits 7:6
    drive_wr(24, 8'hC5, "R5");
    drive_wr(24, 8'h09, "R5");
    drive_wr(24, 8'h12, "R5");
    drive_wr(24, 8'h24, "R5");
    // R6 enhanced mode: source 11 to channel 16
    drive_wr(32, 8'h01, "R6");
    drive_wr(26, 8'h6B, "R6");
    // R9 reserved sources
    drive_wr(24, 8'h6C, "R9");
    drive_wr(27, 8'h37, "R9");
    #1;
    check("R9 reserved gate low", int'(ctr_gate[5]), 0);

    // R8 rates
    count_ticks(16, 2000, 2000, "R8 src11");
    count_ticks(1, 2000, 1000, "R8 src1");
    count_ticks(2, 2000, 100, "R8 src2");
    count_ticks(11, 2000, 10, "R8 src3");
    count_ticks(3, 2000, 1, "R8 src4");
    count_ticks(0, 20000, 1, "R8 src5");
    count_ticks(4, 2000, 0, "R9 src12");

    // R6 leave enhanced mode with any other value
    drive_wr(32, 8'h02, "R6");
    drive_wr(27, 8'hC1, "R6");
    // R12 other offsets ignored
    drive_wr(30, 8'h05, "R12");
    drive_wr(23, 8'h05, "R12");
    drive_wr(31, 8'h01, "R12");

    // R10 wide stride instance
    @(negedge clk);
    w_wr_en = 1'b1; w_wr_addr = 9'h0C8; w_wr_data = 8'h33;
    @(negedge clk);
    w_wr_addr = 9'h0C1; w_wr_data = 8'h01;
    @(negedge clk);
    w_wr_en = 1'b0;
    w_rd_chan = 5'd11; #1;
    check("R10 shifted write", int'(w_rd_clk), 3);
    w_rd_chan = 5'd0; #1;
    check("R10 misaligned ignored", int'(w_rd_clk), 0);
    // R11 out of range read-back is zero
    w_rd_chan = 5'd25; #1;
    check("R11 out of range", int'(w_rd_clk), 0);

    finish_run();
  end
endmodule